// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps many hardware queues of descriptor indices. It does not store each queue in a FIFO buffer of its own. Every descriptor index owns one entry in a shared link memory, and a queue is a singly linked list threaded through those entries. For each queue the block holds a head pointer, a tail pointer and an entry count. It also drives one pending flag per queue, so a consumer can tell when a queue has work without polling.

A requester issues one operation at a time. Each operation carries an opcode, a queue number and a descriptor index, and a push also carries a packet size and a 4-bit hint. A push can add the index at the tail of the queue or at its head. A pop always removes the head entry. It returns that index together with the size and hint that were stored when the index was pushed. Address-to-index translation takes place upstream of this block.

Each entry in the link memory is 40 bits wide. It holds the next-index link, the hint and the packet size. The all-ones link value 0x7FFFF marks the end of a list, and head and tail pointers use the same value to mean "empty".

Top module: `lq_manager`

## Requirements
- R1: After reset, every queue is empty: `pend` is all zero, `op_ready` is 1 and `pop_valid` is 0.
- R2: A push of either kind (op_code 1 = tail, 2 = head) that is accepted on an empty queue sets that queue's `pend` bit from the next cycle on.
- R3: Tail pushes followed by pops on one queue return the indices in push order.
- R4: A head push places its index in front of the existing entries, so the next pop returns it. A head push to an empty queue makes it the only entry.
- R5: Each pop returns the popped index on `pop_index`, with the packet size on `pop_size` (17 bits) and the hint on `pop_hint` (4 bits) that were pushed with that index.
- R6: A pop (op_code 3) of an empty queue returns `pop_null` = 1, with `pop_size` and `pop_hint` at zero. It changes no pointer, count or `pend` bit, and the contents of every queue stay the same.
- R7: A queue's `pend` bit is 1 exactly while its entry count is non-zero, and it drops once the last entry has been popped.
- R8: The cycle after a pop is accepted, `pop_valid` is 1 and `op_ready` is 0, so the requester must hold its next operation. An operation that follows on the same queue sees all pointer updates made by the previous operation.
- R9: Operations on one queue leave the contents and order of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request; it is accepted when `op_ready` is also 1 |
| op_ready | output | 1 | The block can accept an operation this cycle |
| op_code | input | 2 | 0 none, 1 push tail, 2 push head, 3 pop |
| op_queue | input | $clog2(NQ) | Target queue number |
| op_index | input | $clog2(DEPTH) | Descriptor index to push |
| op_size | input | 17 | Packet size stored with the pushed index |
| op_hint | input | 4 | Hint stored with the pushed index (low bits of the pushed value) |
| pend | output | NQ | One bit per queue; 1 while the queue is non-empty |
| pop_valid | output | 1 | A pop result is presented this cycle |
| pop_null | output | 1 | The popped queue was empty |
| pop_index | output | $clog2(DEPTH) | Popped descriptor index |
| pop_size | output | 17 | Packet size of the popped entry |
| pop_hint | output | 4 | Hint of the popped entry |

## Verification
The hardest case to reach is an operation that depends on a link write made in the cycle just before it. Examples are a pop issued right after the push that made a queue non-empty, and a tail push issued while the old tail's link is still being rewritten. The stimulus drives push and pop back to back on one queue and mixes head and tail pushes. A stress loop then spreads many entries over all queues and drains them one queue at a time. A scoreboard model of every list predicts each popped index, size and hint, including null results from empty queues.

// File: rtl/lq_pkg.sv
package lq_pkg;
    localparam int LINK_W = 19;
    localparam int HINT_W = 4;
    localparam int SIZE_W = 17;
    localparam int ENTRY_W = LINK_W + HINT_W + SIZE_W;
    localparam logic [LINK_W-1:0] LINK_NULL = 19'h7FFFF;

    // Entry layout: link [18:0], hint [22:19], size [39:23]
    localparam int HINT_LSB = LINK_W;
    localparam int SIZE_LSB = LINK_W + HINT_W;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_PUSH_TAIL = 2'd1,
        OP_PUSH_HEAD = 2'd2,
        OP_POP       = 2'd3
    } lq_op_e;
endpackage

// File: rtl/lq_link_ram.sv
module lq_link_ram
    import lq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               full_we,
    input  logic [AW-1:0]      full_addr,
    input  logic [ENTRY_W-1:0] full_data,
    input  logic               link_we,
    input  logic [AW-1:0]      link_addr,
    input  logic [LINK_W-1:0]  link_data,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (full_we) begin
            mem[full_addr] <= full_data;
        end
        // relink of the old tail: touches only the link field
        if (link_we) begin
            mem[link_addr][LINK_W-1:0] <= link_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/lq_pend.sv
module lq_pend #(
    parameter int NQ = 8,
    parameter int CW = 11
) (
    input  logic [NQ-1:0][CW-1:0] cnt,
    output logic [NQ-1:0]         pend
);
    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign pend[g] = (cnt[g] != '0);
    end
endmodule

// File: rtl/lq_manager.sv
module lq_manager
    import lq_pkg::*;
#(
    parameter int NQ = 8,
    parameter int DEPTH = 1024,
    localparam int QW = $clog2(NQ),
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_code,
    input  logic [QW-1:0]     op_queue,
    input  logic [AW-1:0]     op_index,
    input  logic [SIZE_W-1:0] op_size,
    input  logic [HINT_W-1:0] op_hint,
    output logic [NQ-1:0]     pend,
    output logic              pop_valid,
    output logic              pop_null,
    output logic [AW-1:0]     pop_index,
    output logic [SIZE_W-1:0] pop_size,
    output logic [HINT_W-1:0] pop_hint
);
    typedef struct packed {
        logic                     busy;
        logic                     pnull;
        logic [QW-1:0]            pq;
        logic [AW-1:0]            pidx;
        logic [NQ-1:0][LINK_W-1:0] head;
        logic [NQ-1:0][LINK_W-1:0] tail;
        logic [NQ-1:0][CW-1:0]    cnt;
    } state_t;

    function automatic state_t reset_state();
        state_t r;
        r = '0;
        for (int i = 0; i < NQ; i++) begin
            r.head[i] = LINK_NULL;
            r.tail[i] = LINK_NULL;
        end
        return r;
    endfunction

    state_t s_d, s_q;

    logic               full_we_d, link_we_d, rd_en_d;
    logic [AW-1:0]      full_addr_d, link_addr_d, rd_addr_d;
    logic [ENTRY_W-1:0] full_data_d;
    logic [LINK_W-1:0]  link_data_d;
    logic [ENTRY_W-1:0] rd_data_q;
    logic               accept;
    logic               q_empty;
    logic [LINK_W-1:0]  idx_link;
    logic [NQ-1:0][CW-1:0] cnt_all;

    assign op_ready = !s_q.busy;
    assign accept   = op_valid && op_ready;
    assign q_empty  = (s_q.cnt[op_queue] == '0);
    assign idx_link = {{(LINK_W-AW){1'b0}}, op_index};
    assign cnt_all  = s_q.cnt;

    always_comb begin
        s_d         = s_q;
        full_we_d   = 1'b0;
        full_addr_d = op_index;
        full_data_d = {op_size, op_hint, LINK_NULL};
        link_we_d   = 1'b0;
        link_addr_d = s_q.tail[op_queue][AW-1:0];
        link_data_d = idx_link;
        rd_en_d     = 1'b0;
        rd_addr_d   = s_q.head[op_queue][AW-1:0];

        if (s_q.busy) begin
            // second cycle of a pop: unlink the head using the entry just read
            s_d.busy = 1'b0;
            if (!s_q.pnull) begin
                s_d.head[s_q.pq] = rd_data_q[LINK_W-1:0];
                s_d.cnt[s_q.pq]  = s_q.cnt[s_q.pq] - CW'(1);
                if (s_q.cnt[s_q.pq] == CW'(1)) begin
                    s_d.head[s_q.pq] = LINK_NULL;
                    s_d.tail[s_q.pq] = LINK_NULL;
                end
            end
        end else if (accept) begin
            case (lq_op_e'(op_code))
                OP_PUSH_TAIL: begin
                    full_we_d = 1'b1;
                    if (q_empty) begin
                        s_d.head[op_queue] = idx_link;
                    end else begin
                        link_we_d = 1'b1;
                    end
                    s_d.tail[op_queue] = idx_link;
                    s_d.cnt[op_queue]  = s_q.cnt[op_queue] + CW'(1);
                end
                OP_PUSH_HEAD: begin
                    full_we_d = 1'b1;
                    if (q_empty) begin
                        s_d.tail[op_queue] = idx_link;
                    end else begin
                        full_data_d[LINK_W-1:0] = s_q.head[op_queue];
                    end
                    s_d.head[op_queue] = idx_link;
                    s_d.cnt[op_queue]  = s_q.cnt[op_queue] + CW'(1);
                end
                OP_POP: begin
                    s_d.busy  = 1'b1;
                    s_d.pnull = q_empty;
                    s_d.pq    = op_queue;
                    s_d.pidx  = s_q.head[op_queue][AW-1:0];
                    rd_en_d   = !q_empty;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= reset_state();
        end else begin
            s_q <= s_d;
        end
    end

    lq_link_ram #(.DEPTH(DEPTH)) i_link_ram (
        .clk       (clk),
        .full_we   (full_we_d),
        .full_addr (full_addr_d),
        .full_data (full_data_d),
        .link_we   (link_we_d),
        .link_addr (link_addr_d),
        .link_data (link_data_d),
        .rd_en     (rd_en_d),
        .rd_addr   (rd_addr_d),
        .rd_data   (rd_data_q)
    );

    lq_pend #(.NQ(NQ), .CW(CW)) i_pend (
        .cnt  (s_q.cnt),
        .pend (pend)
    );

    assign pop_valid = s_q.busy;
    assign pop_null  = s_q.pnull;
    assign pop_index = s_q.pnull ? '0 : s_q.pidx;
    assign pop_size  = s_q.pnull ? '0 : rd_data_q[SIZE_LSB +: SIZE_W];
    assign pop_hint  = s_q.pnull ? '0 : rd_data_q[HINT_LSB +: HINT_W];
endmodule

// File: rtl/lq_manager_chk.sv
module lq_manager_chk #(
    parameter int NQ = 8,
    parameter int QW = 3,
    parameter int CW = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic                  op_ready,
    input logic [1:0]            op_code,
    input logic [QW-1:0]         op_queue,
    input logic [NQ-1:0]         pend,
    input logic                  pop_valid,
    input logic                  pop_null,
    input logic [NQ-1:0][CW-1:0] cnt_all
);
    logic [NQ-1:0] cnt_nz;
    logic          acc_push, acc_pop;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            cnt_nz[i] = (cnt_all[i] != '0);
        end
    end

    assign acc_push = op_valid && op_ready && (op_code == 2'd1 || op_code == 2'd2);
    assign acc_pop  = op_valid && op_ready && (op_code == 2'd3);

    AST_PUSH_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_push |=> pend[$past(op_queue)]); // R2

    AST_EMPTY_POP_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pop && !pend[op_queue]) |=> (pop_valid && pop_null)); // R6

    AST_NULL_POP_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && pop_null) |=> $stable(pend)); // R6

    AST_PEND_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        pend == cnt_nz); // R7

    AST_POP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pop |=> (pop_valid && !op_ready)); // R8

    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> !pop_valid); // R8
endmodule

bind lq_manager lq_manager_chk #(.NQ(NQ), .QW(QW), .CW(CW)) i_lq_manager_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_code   (op_code),
    .op_queue  (op_queue),
    .pend      (pend),
    .pop_valid (pop_valid),
    .pop_null  (pop_null),
    .cnt_all   (cnt_all)
);

// File: tb/test_lq_manager.sv
module test_lq_manager;
    localparam int NQ = 8;
    localparam int DEPTH = 1024;
    localparam int QW = $clog2(NQ);
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [1:0]    op_code = '0;
    logic [QW-1:0] op_queue = '0;
    logic [AW-1:0] op_index = '0;
    logic [16:0]   op_size = '0;
    logic [3:0]    op_hint = '0;
    logic [NQ-1:0] pend;
    logic          pop_valid, pop_null;
    logic [AW-1:0] pop_index;
    logic [16:0]   pop_size;
    logic [3:0]    pop_hint;

    lq_manager #(.NQ(NQ), .DEPTH(DEPTH)) i_lq_manager (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .op_queue(op_queue), .op_index(op_index),
        .op_size(op_size), .op_hint(op_hint), .pend(pend),
        .pop_valid(pop_valid), .pop_null(pop_null), .pop_index(pop_index),
        .pop_size(pop_size), .pop_hint(pop_hint)
    );

    typedef struct {
        bit    nul;
        int    idx;
        int    size;
        int    hint;
        string req;
    } item_t;

    item_t mdl[NQ][$];
    item_t exp_q[$];
    int checks = 0;
    int errors = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver: called at a falling edge, returns at a falling edge
    task automatic issue(logic [1:0] code, int q, int idx, int sz, int hn);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1;
        op_code  = code;
        op_queue = QW'(q);
        op_index = AW'(idx);
        op_size  = 17'(sz);
        op_hint  = 4'(hn);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic push(bit at_head, int q, int idx, int sz, int hn);
        item_t it;
        it.nul = 0; it.idx = idx; it.size = sz; it.hint = hn; it.req = "";
        if (at_head) mdl[q].push_front(it);
        else mdl[q].push_back(it);
        issue(at_head ? 2'd2 : 2'd1, q, idx, sz, hn);
    endtask

    task automatic pop(int q, string req);
        item_t it;
        if (mdl[q].size() == 0) begin
            it.nul = 1; it.idx = 0; it.size = 0; it.hint = 0;
        end else begin
            it = mdl[q].pop_front();
        end
        it.req = req;
        exp_q.push_back(it);
        issue(2'd3, q, 0, 0, 0);
    endtask

    task automatic check_pend(string req);
        @(negedge clk);
        @(negedge clk);
        for (int q = 0; q < NQ; q++) begin
            chk(pend[q] == (mdl[q].size() != 0), req, $sformatf("pend[%0d]", q),
                pend[q], mdl[q].size() != 0);
        end
    endtask

    // monitor: compares each pop result against the scoreboard
    always @(negedge clk) begin
        item_t e;
        if (rst_n && pop_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R5", "unexpected pop_valid", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(pop_null == e.nul, e.req, "pop_null", pop_null, e.nul);
                chk(pop_index == AW'(e.idx), e.req, "pop_index", pop_index, e.idx);
                chk(pop_size == 17'(e.size), "R5", "pop_size", pop_size, e.size);
                chk(pop_hint == 4'(e.hint), "R5", "pop_hint", pop_hint, e.hint);
                chk(op_ready == 1'b0, "R8", "op_ready during pop result", op_ready, 0);
            end
        end
    end

    initial begin
        #(4 * 100000);
        chk(0, "watchdog", "run did not finish", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(pend == '0, "R1", "pend after reset", pend, 0);
        chk(op_ready == 1'b1, "R1", "op_ready after reset", op_ready, 1);
        chk(pop_valid == 1'b0, "R1", "pop_valid after reset", pop_valid, 0);

        // R6: pop of an empty queue
        pop(0, "R6");
        check_pend("R6");

        // R3: tail pushes come out in order; R2 pend on first push
        push(0, 0, 5, 1500, 4'h3);
        push(0, 0, 9, 64, 4'hA);
        push(0, 0, 3, 131071, 4'hF);
        check_pend("R2");
        pop(0, "R3"); pop(0, "R3"); pop(0, "R3");
        check_pend("R7");

        // R4: head pushes go in front
        push(0, 1, 10, 100, 1);
        push(1, 1, 11, 200, 2);
        push(1, 1, 12, 300, 3);
        pop(1, "R4"); pop(1, "R4"); pop(1, "R4");
        push(1, 2, 20, 77, 7);
        check_pend("R2");
        pop(2, "R4");
        check_pend("R7");

        // R9: interleaved queues stay independent; null pop in between
        push(0, 3, 30, 11, 1);
        push(0, 4, 40, 22, 2);
        push(1, 3, 31, 33, 3);
        push(0, 4, 41, 44, 4);
        pop(5, "R6");
        check_pend("R9");
        pop(4, "R9"); pop(3, "R9"); pop(4, "R9"); pop(3, "R9");
        check_pend("R7");

        // R8: back-to-back push and pop on one queue
        push(0, 6, 50, 500, 5);
        pop(6, "R8");
        push(0, 6, 51, 510, 6);
        push(0, 6, 52, 520, 7);
        pop(6, "R8");
        push(1, 6, 53, 530, 8);
        pop(6, "R8");
        pop(6, "R8");
        pop(6, "R8");
        check_pend("R8");

        // R3/R4/R9 stress: mixed ends across all queues, then drain
        for (int i = 0; i < 48; i++) begin
            push(i % 3 == 2, i % NQ, 100 + i, (i * 2731) % 131072, i % 16);
        end
        check_pend("R9");
        for (int q = 0; q < NQ; q++) begin
            while (mdl[q].size() != 0) pop(q, "R3");
        end
        for (int q = 0; q < NQ; q++) pop(q, "R6");
        check_pend("R7");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "results outstanding", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule